// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block keeps a small number of recently used page-table entries so that a virtual page number can be turned into a physical page number without walking the page table. It holds sixteen entries, arranged as four sets of four ways. Each stored entry is a full page-table entry: a valid flag, the tag taken from the virtual page number, the physical page number, and a three-bit access-rights field.

A lookup presents an 8-bit virtual page number. The two low bits pick the set and the six high bits are the tag. All four ways of that set are compared in parallel. One cycle later the block reports either a hit, with the physical page number and rights, or a miss. After a miss, an external page-table unit supplies the entry on the fill port, and the block writes it into the set. An invalidate-all input empties the whole structure in one cycle, for example when the running process changes.

The response path is a two-state machine. ST_IDLE means no result is presented. ST_RESP means a registered result is on the outputs. Both states go to ST_RESP in a cycle where a lookup is requested, and to ST_IDLE otherwise. Each fill takes one of four placement choices. FK_REUSE overwrites a way that already holds the same page. FK_FREE takes the lowest-numbered empty way. FK_EVICT replaces the way named by the round-robin pointer of that set. FK_NONE means no fill is taking place.

Top module: `tlb_top`

## Requirements
- R1: After reset every entry is invalid and no result is presented, so the first lookup of any page misses.
- R2: A lookup requested in cycle N gives rs_valid high in cycle N+1 with exactly one of rs_hit and rs_miss set. While rs_valid is low, rs_hit, rs_miss, rs_ppn and rs_perm are all zero.
- R3: Bits [1:0] of the virtual page number select the set and bits [7:2] form the tag. A hit needs a valid way in the selected set whose tag is equal, so a page that differs only in set or only in tag misses.
- R4: On a hit, rs_ppn and rs_perm equal the physical page number and rights written by the most recent fill of that page.
- R5: On a miss, rs_ppn and rs_perm are zero.
- R6: A fill of a page already present overwrites the way that holds it. No other entry of the set is disturbed.
- R7: A fill of a new page into a set that has empty ways takes the lowest-numbered empty way, and leaves the valid entries in place.
- R8: A fill of a new page into a full set replaces the way named by that set's 2-bit round-robin pointer. The pointer starts at way 0 after reset and advances by one only on such a replacement.
- R9: invalidate-all clears every entry at the next clock edge, so a lookup in any later cycle misses until a new fill.
- R10: A fill requested in the same cycle as invalidate-all is dropped.
- R11: A lookup sees the contents held before the clock edge at which it is requested. A fill or invalidate in the same cycle affects only later lookups.
- R12: Each set has its own round-robin pointer. A replacement in one set does not move the pointer of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 8 | Virtual page number to translate |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | 8 | Virtual page number of the entry being filled |
| fl_ppn | input | 6 | Physical page number of the filled entry |
| fl_perm | input | 3 | Access rights of the filled entry |
| flush_all | input | 1 | Invalidate every entry |
| rs_valid | output | 1 | A lookup result is presented |
| rs_hit | output | 1 | Result is a hit |
| rs_miss | output | 1 | Result is a miss |
| rs_ppn | output | 6 | Physical page number on a hit, else zero |
| rs_perm | output | 3 | Access rights on a hit, else zero |

## Verification
A lookup driven in one cycle produces its result in the next cycle and in no other. The bench pushes the expected result at the moment it drives the request, and the monitor pops one expectation for each cycle in which rs_valid is high. It samples on the falling edge, half a cycle after the result registers change. A fill or invalidate changes the array at the edge that follows the request, so its effect appears only in lookups requested one cycle later or after that. Lookups driven in the same cycle as a fill or invalidate are therefore expected to report the old contents.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W    = 8;
    localparam int SET_BITS = 2;
    localparam int WAYS     = 4;
    localparam int PPN_W    = 6;
    localparam int PERM_W   = 3;

    localparam int SETS  = 1 << SET_BITS;
    localparam int TAG_W = VPN_W - SET_BITS;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [VPN_W-1:0]    vpn_t;
    typedef logic [SET_BITS-1:0] set_idx_t;
    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic [WAY_W-1:0]    way_idx_t;
    typedef logic [PPN_W-1:0]    ppn_t;
    typedef logic [PERM_W-1:0]   perm_t;

    typedef struct packed {
        logic  vld;
        tag_t  tag;
        ppn_t  ppn;
        perm_t perm;
    } tlb_ent_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_t;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_REUSE = 2'd1,
        FK_FREE  = 2'd2,
        FK_EVICT = 2'd3
    } fill_kind_t;

    function automatic set_idx_t vpn_set(input vpn_t v);
        return v[SET_BITS-1:0];
    endfunction

    function automatic tag_t vpn_tag(input vpn_t v);
        return v[VPN_W-1:SET_BITS];
    endfunction
endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_all,
    input  logic     wr_en,
    input  set_idx_t wr_set,
    input  way_idx_t wr_way,
    input  tlb_ent_t wr_ent,
    output tlb_ent_t ent_o [SETS][WAYS]
);
    for (genvar gs = 0; gs < SETS; gs++) begin : g_set
        for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
            tlb_ent_t q;
            logic     sel;

            assign sel = wr_en && (wr_set == set_idx_t'(gs)) && (wr_way == way_idx_t'(gw));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (clr_all) begin
                    q.vld <= 1'b0;
                end else if (sel) begin
                    q <= wr_ent;
                end
            end

            assign ent_o[gs][gw] = q;
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_ent_t row [WAYS],
    input  tag_t     tag,
    output logic     hit,
    output way_idx_t way
);
    logic [WAYS-1:0] eq;

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_cmp
        assign eq[gw] = row[gw].vld && (row[gw].tag == tag);
    end

    // Lowest-numbered matching way wins.
    always_comb begin
        hit = |eq;
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) way = way_idx_t'(w);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit,
    input  set_idx_t        set,
    input  logic [WAYS-1:0] vld_row,
    input  logic            match_hit,
    input  way_idx_t        match_way,
    output way_idx_t        victim
);
    way_idx_t   ptr_arr [SETS];
    fill_kind_t kind;
    logic       free_any;
    way_idx_t   free_way;

    always_comb begin
        free_any = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_row[w]) begin
                free_any = 1'b1;
                free_way = way_idx_t'(w);
            end
        end
    end

    always_comb begin
        if (!commit)        kind = FK_NONE;
        else if (match_hit) kind = FK_REUSE;
        else if (free_any)  kind = FK_FREE;
        else                kind = FK_EVICT;
    end

    always_comb begin
        unique case (kind)
            FK_REUSE: victim = match_way;
            FK_FREE:  victim = free_way;
            FK_EVICT: victim = ptr_arr[set];
            FK_NONE:  victim = '0;
        endcase
    end

    for (genvar gs = 0; gs < SETS; gs++) begin : g_ptr
        way_idx_t q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (kind == FK_EVICT && set == set_idx_t'(gs)) begin
                q <= q + 1'b1;
            end
        end

        assign ptr_arr[gs] = q;
    end
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              fl_valid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [PPN_W-1:0]  fl_ppn,
    input  logic [PERM_W-1:0] fl_perm,
    input  logic              flush_all,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic              rs_miss,
    output logic [PPN_W-1:0]  rs_ppn,
    output logic [PERM_W-1:0] rs_perm
);
    tlb_ent_t ent    [SETS][WAYS];
    tlb_ent_t lk_row [WAYS];
    tlb_ent_t fl_row [WAYS];
    logic [WAYS-1:0] fl_vld_row;

    logic     lk_hit, fl_hit, wr_en;
    way_idx_t lk_way, fl_way, wr_way;
    tlb_ent_t wr_ent;

    rsp_state_t state_q, state_d;
    logic       hit_q;
    ppn_t       ppn_q;
    perm_t      perm_q;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            lk_row[w]     = ent[vpn_set(lk_vpn)][w];
            fl_row[w]     = ent[vpn_set(fl_vpn)][w];
            fl_vld_row[w] = fl_row[w].vld;
        end
    end

    tlb_match u_lk_match (
        .row (lk_row),
        .tag (vpn_tag(lk_vpn)),
        .hit (lk_hit),
        .way (lk_way)
    );

    tlb_match u_fl_match (
        .row (fl_row),
        .tag (vpn_tag(fl_vpn)),
        .hit (fl_hit),
        .way (fl_way)
    );

    // Invalidate-all takes precedence over a fill in the same cycle.
    assign wr_en  = fl_valid && !flush_all;
    assign wr_ent = '{vld: 1'b1, tag: vpn_tag(fl_vpn), ppn: fl_ppn, perm: fl_perm};

    tlb_victim u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (wr_en),
        .set       (vpn_set(fl_vpn)),
        .vld_row   (fl_vld_row),
        .match_hit (fl_hit),
        .match_way (fl_way),
        .victim    (wr_way)
    );

    tlb_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (flush_all),
        .wr_en   (wr_en),
        .wr_set  (vpn_set(fl_vpn)),
        .wr_way  (wr_way),
        .wr_ent  (wr_ent),
        .ent_o   (ent)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = lk_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = lk_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            ppn_q  <= '0;
            perm_q <= '0;
        end else if (lk_valid) begin
            hit_q  <= lk_hit;
            ppn_q  <= lk_hit ? lk_row[lk_way].ppn  : '0;
            perm_q <= lk_hit ? lk_row[lk_way].perm : '0;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: begin
                rs_valid = 1'b0;
                rs_hit   = 1'b0;
                rs_miss  = 1'b0;
                rs_ppn   = '0;
                rs_perm  = '0;
            end
            ST_RESP: begin
                rs_valid = 1'b1;
                rs_hit   = hit_q;
                rs_miss  = !hit_q;
                rs_ppn   = ppn_q;
                rs_perm  = perm_q;
            end
        endcase
    end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic              fl_valid,
    input logic [VPN_W-1:0]  fl_vpn,
    input logic [PPN_W-1:0]  fl_ppn,
    input logic [PERM_W-1:0] fl_perm,
    input logic              flush_all,
    input logic              rs_valid,
    input logic              rs_hit,
    input logic              rs_miss,
    input logic [PPN_W-1:0]  rs_ppn,
    input logic [PERM_W-1:0] rs_perm
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> (rs_hit != rs_miss));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (!rs_hit && !rs_miss && rs_ppn == '0 && rs_perm == '0));

    // R5
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_miss |-> (rs_ppn == '0 && rs_perm == '0));

    // R9
    flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush_all) && lk_valid) |=> rs_miss);

    // R4
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fl_valid) && !$past(flush_all) && lk_valid && lk_vpn == $past(fl_vpn))
        |=> (rs_hit && rs_ppn == $past(fl_ppn, 2) && rs_perm == $past(fl_perm, 2)));
endmodule

bind tlb_top tlb_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vpn    (lk_vpn),
    .fl_valid  (fl_valid),
    .fl_vpn    (fl_vpn),
    .fl_ppn    (fl_ppn),
    .fl_perm   (fl_perm),
    .flush_all (flush_all),
    .rs_valid  (rs_valid),
    .rs_hit    (rs_hit),
    .rs_miss   (rs_miss),
    .rs_ppn    (rs_ppn),
    .rs_perm   (rs_perm)
);

// File: tb/tlb_top_tb_top.sv
module tlb_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lk_valid = 1'b0;
    logic [7:0] lk_vpn = '0;
    logic       fl_valid = 1'b0;
    logic [7:0] fl_vpn = '0;
    logic [5:0] fl_ppn = '0;
    logic [2:0] fl_perm = '0;
    logic       flush_all = 1'b0;
    logic       rs_valid, rs_hit, rs_miss;
    logic [5:0] rs_ppn;
    logic [2:0] rs_perm;

    int checks = 0;
    int fails  = 0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    tlb_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn),
        .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .fl_perm(fl_perm),
        .flush_all(flush_all),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss),
        .rs_ppn(rs_ppn), .rs_perm(rs_perm)
    );

    task automatic drive(input logic lk, input logic [7:0] lv, input logic fl,
                         input logic [7:0] fv, input logic [5:0] fp,
                         input logic [2:0] fm, input logic fa);
        @(negedge clk);
        lk_valid  = lk;
        lk_vpn    = lv;
        fl_valid  = fl;
        fl_vpn    = fv;
        fl_ppn    = fp;
        fl_perm   = fm;
        flush_all = fa;
    endtask

    task automatic push_exp(input logic h, input logic [5:0] p, input logic [2:0] m, input string rq);
        exp_q.push_back({h, p, m});
        tag_q.push_back(rq);
    endtask

    task automatic look(input logic [7:0] v, input logic h, input logic [5:0] p,
                        input logic [2:0] m, input string rq);
        push_exp(h, p, m, rq);
        drive(1'b1, v, 1'b0, 8'h00, 6'h00, 3'b000, 1'b0);
    endtask

    task automatic fill(input logic [7:0] v, input logic [5:0] p, input logic [2:0] m);
        drive(1'b0, 8'h00, 1'b1, v, p, m, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 8'h00, 1'b0, 8'h00, 6'h00, 3'b000, 1'b0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rs_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2: unexpected result, actual hit=%0b ppn=%0h expected none",
                         rs_hit, rs_ppn);
            end else begin
                logic [9:0] e;
                string      rq;
                e  = exp_q.pop_front();
                rq = tag_q.pop_front();
                if ({rs_hit, rs_ppn, rs_perm} != e || rs_miss != !e[9]) begin
                    fails++;
                    $display("FAIL %s: actual hit=%0b miss=%0b ppn=%0h perm=%0h expected hit=%0b ppn=%0h perm=%0h",
                             rq, rs_hit, rs_miss, rs_ppn, rs_perm, e[9], e[8:3], e[2:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 / R2: reset state, nothing presented
        checks++;
        if (rs_valid || rs_hit || rs_miss || rs_ppn != 0 || rs_perm != 0) begin
            fails++;
            $display("FAIL R1: actual v=%0b h=%0b m=%0b expected all zero", rs_valid, rs_hit, rs_miss);
        end
        look(8'h00, 1'b0, 6'h00, 3'd0, "R1");
        look(8'h3A, 1'b0, 6'h00, 3'd0, "R1");

        fill(8'h0D, 6'h2D, 3'd3);
        look(8'h0D, 1'b1, 6'h2D, 3'd3, "R4");
        look(8'h0C, 1'b0, 6'h00, 3'd0, "R3");
        look(8'h4D, 1'b0, 6'h00, 3'd0, "R3");
        look(8'h0D, 1'b1, 6'h2D, 3'd3, "R5");

        // set 0 filled into empty ways
        fill(8'h04, 6'h11, 3'd1);
        fill(8'h08, 6'h12, 3'd2);
        fill(8'h0C, 6'h13, 3'd3);
        fill(8'h10, 6'h14, 3'd4);
        look(8'h04, 1'b1, 6'h11, 3'd1, "R7");
        look(8'h08, 1'b1, 6'h12, 3'd2, "R7");
        look(8'h0C, 1'b1, 6'h13, 3'd3, "R7");
        look(8'h10, 1'b1, 6'h14, 3'd4, "R7");

        // refill of a present page
        fill(8'h08, 6'h3F, 3'd5);
        look(8'h08, 1'b1, 6'h3F, 3'd5, "R6");
        look(8'h04, 1'b1, 6'h11, 3'd1, "R6");
        look(8'h0C, 1'b1, 6'h13, 3'd3, "R6");
        look(8'h10, 1'b1, 6'h14, 3'd4, "R6");

        // replacement in full set 0: way 0 then way 1
        fill(8'h14, 6'h15, 3'd6);
        look(8'h04, 1'b0, 6'h00, 3'd0, "R8");
        look(8'h14, 1'b1, 6'h15, 3'd6, "R8");
        look(8'h08, 1'b1, 6'h3F, 3'd5, "R8");
        fill(8'h18, 6'h16, 3'd7);
        look(8'h08, 1'b0, 6'h00, 3'd0, "R8");
        look(8'h0C, 1'b1, 6'h13, 3'd3, "R8");
        look(8'h18, 1'b1, 6'h16, 3'd7, "R8");

        // set 1 pointer independent of set 0
        fill(8'h11, 6'h21, 3'd1);
        fill(8'h15, 6'h22, 3'd2);
        fill(8'h19, 6'h23, 3'd3);
        fill(8'h1D, 6'h24, 3'd4);
        look(8'h0D, 1'b0, 6'h00, 3'd0, "R12");
        look(8'h11, 1'b1, 6'h21, 3'd1, "R12");
        look(8'h1D, 1'b1, 6'h24, 3'd4, "R12");
        fill(8'h1C, 6'h25, 3'd5);
        look(8'h0C, 1'b0, 6'h00, 3'd0, "R12");
        look(8'h10, 1'b1, 6'h14, 3'd4, "R12");
        look(8'h1C, 1'b1, 6'h25, 3'd5, "R12");

        // lookup and fill of the same page in one cycle
        push_exp(1'b0, 6'h00, 3'd0, "R11");
        drive(1'b1, 8'h21, 1'b1, 8'h21, 6'h30, 3'd6, 1'b0);
        look(8'h21, 1'b1, 6'h30, 3'd6, "R11");
        look(8'h11, 1'b0, 6'h00, 3'd0, "R8");

        // invalidate-all with a lookup and a fill in the same cycle
        push_exp(1'b1, 6'h30, 3'd6, "R11");
        drive(1'b1, 8'h21, 1'b1, 8'h22, 6'h31, 3'd7, 1'b1);
        look(8'h21, 1'b0, 6'h00, 3'd0, "R9");
        look(8'h22, 1'b0, 6'h00, 3'd0, "R10");
        look(8'h1D, 1'b0, 6'h00, 3'd0, "R9");
        look(8'h14, 1'b0, 6'h00, 3'd0, "R9");

        fill(8'h02, 6'h0A, 3'd3);
        look(8'h02, 1'b1, 6'h0A, 3'd3, "R7");
        idle(3);

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2: actual %0d results outstanding expected 0", exp_q.size());
        end
        summary();
        $finish;
    end
endmodule